// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls a 16-pin parallel port. Each pin is either a general-purpose I/O line or is handed to an on-chip peripheral. Three registers on a simple synchronous bus set up the port. The pin-assignment register chooses between GPIO and dedicated use. The direction register sets the pin direction in GPIO mode. In dedicated mode the same bit chooses between two alternate peripheral functions, called A and B. The data register holds an output latch, and reading it returns the pin levels.

On the peripheral side, each pin has an output and an output-enable for function A and for function B. Each pin also has a receive input towards function A and towards function B. When a pin does not feed a function-A input, that input gets a default instead. The default is logic low for most pins. Four clock pins take a baud-rate-generator clock in place of the pin. One clock input copies the function-A input of another pin. Pin levels are passed through a two-flop synchronizer before any use inside the block.

The pin pads, the serial peripherals, the timers and the clock generators are outside the block. They connect through plain ports.

Top module: `gpio_mux_port`

## Requirements
- R1: A synchronous active-low reset clears the assignment and direction registers. After reset every pin is a GPIO input with `pin_oe` all zero, and both registers read back as 0.
- R2: A pin with assignment bit 0 is a GPIO pin. If its direction bit is 1, its `pin_oe` bit is 1 and its `pin_out` bit equals the output latch. If its direction bit is 0, its `pin_oe` bit is 0.
- R3: A write to the data register always loads the output latch, even for pins that are inputs. When such a pin is later made a GPIO output, it drives the stored value.
- R4: A read of the data register returns the synchronized pin level, never the latch. A change on `pin_in` is first seen by a read issued on the third rising edge after the change. Read data appears on `bus_rdata` after the edge that takes the read.
- R5: A pin with assignment bit 1 is a dedicated pin. Direction bit 0 selects function A and direction bit 1 selects function B. The pin's `pin_out` and `pin_oe` come from the selected function's `fa_out`/`fa_oe` or `fb_out`/`fb_oe`.
- R6: A selected function that is receive-only, or that does not exist, never turns on the driver. Such a pin has `pin_oe` 0 and `pin_out` 0. With the default parameters, function A is receive-only on pins 0, 2, 4, 6 and 8 to 15. Function B is receive-only on pins 0, 5 and 7, and does not exist on pins 2 and 3.
- R7: `fa_in[p]` carries the synchronized pin level only when pin p is dedicated with function A selected. Otherwise it carries a default. Pins 8, 10, 12 and 14 take `brg_clk[0]` to `brg_clk[3]` in that order. Pin 11 takes the current `fa_in[15]`. All other pins take 0.
- R8: `fb_in[p]` carries the synchronized pin level only when pin p is dedicated with an existing function B selected. Otherwise it is 0.
- R9: The bus decodes `bus_addr[3:2]` as follows: 0 is assignment, 1 is direction, 2 is data, and 3 is unused. `bus_be[0]` writes bits 7:0 and `bus_be[1]` writes bits 15:8. A write to word 3 changes nothing, and a read of word 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the register |
| bus_be | input | 2 | Byte write enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad driver enables |
| fa_out | input | 16 | Function A peripheral outputs |
| fa_oe | input | 16 | Function A peripheral output enables |
| fb_out | input | 16 | Function B peripheral outputs |
| fb_oe | input | 16 | Function B peripheral output enables |
| fa_in | output | 16 | Inputs to function A peripherals |
| fb_in | output | 16 | Inputs to function B peripherals |
| brg_clk | input | 4 | Baud-rate-generator clocks used as defaults |

## Verification
The bench checks the following corner cases.

- It writes the latch while every pin is an input, then turns the pins into outputs. A design that gated latch writes by direction would drive stale data.
- It drives a pin level that differs from the latch and reads the data register on three successive edges. A design that returned the latch, or that had one synchronizer flop too few or too many, would give the new value at the wrong read.
- It selects receive-only functions while the peripheral asserts its enable. A design that forwarded that enable would drive against an incoming signal.
- It frees pin 15 so that pin 11's default follows it, and it uses byte-enable writes and the unused word. These catch a wrong default route, a lane that is written without its enable, and a write that aliases onto a real register.

// File: rtl/gpio_mux_pkg.sv
// Shared definitions for the multiplexed GPIO port.
// Assumes pins 8..15 exist whenever a clock default is used.
package gpio_mux_pkg;

    // Source of the default value fed to a function-A peripheral input.
    typedef enum logic [2:0] {
        DF_LOW  = 3'd0,
        DF_BRG0 = 3'd1,
        DF_BRG1 = 3'd2,
        DF_BRG2 = 3'd3,
        DF_BRG3 = 3'd4,
        DF_PEER = 3'd5
    } dflt_e;

    // Pin whose function-A input is copied by a DF_PEER default.
    localparam int PEER_SRC = 15;

    // Default source chosen for pin p.
    function automatic dflt_e dflt_of(input int p);
        case (p)
            8:       return DF_BRG0;
            10:      return DF_BRG1;
            12:      return DF_BRG2;
            14:      return DF_BRG3;
            11:      return DF_PEER;
            default: return DF_LOW;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes each bit may be treated independently (no bus coherency needed).
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Register file: assignment, direction and data latch with byte enables,
// plus a registered read port. Assumes NPINS is a multiple of 8.
module gpio_regs #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [3:0]       addr,
    input  logic [NPINS/8-1:0] be,
    input  logic [NPINS-1:0] wdata,
    input  logic [NPINS-1:0] pin_lvl,
    output logic [NPINS-1:0] asg_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] lat_q,
    output logic [NPINS-1:0] rdata
);
    localparam int NBYTES = NPINS / 8;
    localparam logic [1:0] W_ASG = 2'd0;
    localparam logic [1:0] W_DIR = 2'd1;
    localparam logic [1:0] W_DAT = 2'd2;

    logic [1:0] word;
    assign word = addr[3:2];

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        // Per-byte register update; assignment and direction reset to GPIO input.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                asg_q[b*8 +: 8] <= '0;
                dir_q[b*8 +: 8] <= '0;
                lat_q[b*8 +: 8] <= '0;
            end else if (wr && be[b]) begin
                if (word == W_ASG) asg_q[b*8 +: 8] <= wdata[b*8 +: 8];
                if (word == W_DIR) dir_q[b*8 +: 8] <= wdata[b*8 +: 8];
                if (word == W_DAT) lat_q[b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    // Registered read: data word returns pin levels, unused word returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            case (word)
                W_ASG:   rdata <= asg_q;
                W_DIR:   rdata <= dir_q;
                W_DAT:   rdata <= pin_lvl;
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pin_cell.sv
// One pin's multiplexer: GPIO versus dedicated, function A versus B,
// driver enable and peripheral input routing. Purely combinational.
module gpio_pin_cell #(
    parameter bit HAS_A = 1'b1,
    parameter bit HAS_B = 1'b1,
    parameter bit A_RX  = 1'b0,
    parameter bit B_RX  = 1'b0
) (
    input  logic asg,
    input  logic dir,
    input  logic lat,
    input  logic lvl,
    input  logic fa_o,
    input  logic fa_e,
    input  logic fb_o,
    input  logic fb_e,
    input  logic dflt,
    output logic po,
    output logic pe,
    output logic fa_i,
    output logic fb_i
);
    logic fn_exists;
    logic fn_rx;
    logic fn_drives;

    assign fn_exists = dir ? HAS_B : HAS_A;
    assign fn_rx     = dir ? B_RX  : A_RX;
    assign fn_drives = fn_exists && !fn_rx;

    // Select pad value and enable from GPIO latch or selected peripheral.
    always_comb begin
        if (!asg) begin
            po = lat;
            pe = dir;
        end else if (fn_drives) begin
            po = dir ? fb_o : fa_o;
            pe = dir ? fb_e : fa_e;
        end else begin
            po = 1'b0;
            pe = 1'b0;
        end
    end

    // Route pad level to the selected function, defaults elsewhere.
    assign fa_i = (asg && !dir && HAS_A) ? lvl : dflt;
    assign fb_i = (asg &&  dir && HAS_B) ? lvl : 1'b0;
endmodule

// File: rtl/gpio_mux_port.sv
// Top of the multiplexed GPIO port: registers, synchronizer and one
// pin cell per pin. Assumes the peer-default source pin defaults low.
module gpio_mux_port #(
    parameter int          NPINS     = 16,
    parameter int          SYNC_LEN  = 2,
    parameter logic [15:0] A_EXISTS  = 16'hFFFF,
    parameter logic [15:0] B_EXISTS  = 16'hFFF3,
    parameter logic [15:0] A_RX_ONLY = 16'hFF55,
    parameter logic [15:0] B_RX_ONLY = 16'h00A1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [3:0]         bus_addr,
    input  logic [NPINS/8-1:0] bus_be,
    input  logic [NPINS-1:0]   bus_wdata,
    output logic [NPINS-1:0]   bus_rdata,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   pin_out,
    output logic [NPINS-1:0]   pin_oe,
    input  logic [NPINS-1:0]   fa_out,
    input  logic [NPINS-1:0]   fa_oe,
    input  logic [NPINS-1:0]   fb_out,
    input  logic [NPINS-1:0]   fb_oe,
    output logic [NPINS-1:0]   fa_in,
    output logic [NPINS-1:0]   fb_in,
    input  logic [3:0]         brg_clk
);
    import gpio_mux_pkg::*;

    logic [NPINS-1:0] asg_q, dir_q, lat_q, pin_lvl, dflt;
    logic             peer_val;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_lvl)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
        .addr(bus_addr), .be(bus_be), .wdata(bus_wdata), .pin_lvl(pin_lvl),
        .asg_q(asg_q), .dir_q(dir_q), .lat_q(lat_q), .rdata(bus_rdata)
    );

    // Function-A input of the peer source pin, built from state to avoid a loop.
    if (PEER_SRC < NPINS) begin : g_peer
        assign peer_val = (asg_q[PEER_SRC] && !dir_q[PEER_SRC] && A_EXISTS[PEER_SRC])
                          ? pin_lvl[PEER_SRC] : 1'b0;
    end else begin : g_nopeer
        assign peer_val = 1'b0;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam dflt_e CODE = dflt_of(p);

        if (CODE == DF_BRG0)      begin : g_d assign dflt[p] = brg_clk[0]; end
        else if (CODE == DF_BRG1) begin : g_d assign dflt[p] = brg_clk[1]; end
        else if (CODE == DF_BRG2) begin : g_d assign dflt[p] = brg_clk[2]; end
        else if (CODE == DF_BRG3) begin : g_d assign dflt[p] = brg_clk[3]; end
        else if (CODE == DF_PEER) begin : g_d assign dflt[p] = peer_val;   end
        else                      begin : g_d assign dflt[p] = 1'b0;       end

        gpio_pin_cell #(
            .HAS_A(A_EXISTS[p]), .HAS_B(B_EXISTS[p]),
            .A_RX(A_RX_ONLY[p]), .B_RX(B_RX_ONLY[p])
        ) u_cell (
            .asg(asg_q[p]), .dir(dir_q[p]), .lat(lat_q[p]), .lvl(pin_lvl[p]),
            .fa_o(fa_out[p]), .fa_e(fa_oe[p]), .fb_o(fb_out[p]), .fb_e(fb_oe[p]),
            .dflt(dflt[p]),
            .po(pin_out[p]), .pe(pin_oe[p]), .fa_i(fa_in[p]), .fb_i(fb_in[p])
        );
    end
endmodule

// File: rtl/gpio_mux_port_chk.sv
// Property checker for gpio_mux_port, attached by bind.
// Observes register state and pin/peripheral ports.
module gpio_mux_port_chk #(
    parameter int          NPINS     = 16,
    parameter logic [15:0] B_EXISTS  = 16'hFFF3,
    parameter logic [15:0] A_RX_ONLY = 16'hFF55
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic [3:0]       bus_addr,
    input logic [NPINS-1:0] bus_rdata,
    input logic [NPINS-1:0] asg,
    input logic [NPINS-1:0] dir,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] fa_in,
    input logic [NPINS-1:0] fb_in
);
    import gpio_mux_pkg::*;

    logic [NPINS-1:0] low_dflt;

    // Pins whose function-A default is a constant low.
    always_comb begin
        for (int p = 0; p < NPINS; p++) low_dflt[p] = (dflt_of(p) == DF_LOW);
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0));

    assert_gpio_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~asg & ~dir & pin_oe) == '0));

    assert_gpio_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~asg & dir & ~pin_oe) == '0));

    assert_rx_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((asg & ~dir & A_RX_ONLY[NPINS-1:0] & pin_oe) == '0));

    assert_low_dflt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(asg & ~dir) & low_dflt & fa_in) == '0));

    assert_b_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(asg & dir & B_EXISTS[NPINS-1:0]) & fb_in) == '0));

    assert_unused_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[3:2] == 2'd3) |=> (bus_rdata == '0));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .NPINS(NPINS), .B_EXISTS(B_EXISTS), .A_RX_ONLY(A_RX_ONLY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .asg(asg_q), .dir(dir_q), .pin_oe(pin_oe),
    .fa_in(fa_in), .fb_in(fb_in)
);

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [15:0] pin_in = '0, pin_out, pin_oe;
    logic [15:0] fa_out = 16'h0F0F, fa_oe = 16'hFFFF;
    logic [15:0] fb_out = 16'h3333, fb_oe = 16'hFFFF;
    logic [15:0] fa_in, fb_in;
    logic [3:0]  brg_clk = 4'b0101;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] rd_v;

    always #2 clk = ~clk;

    gpio_mux_port u0 (.*);

    typedef struct packed {
        logic [15:0] asg, dir, oe, out, ain, bin;
    } vec_t;

    // Pin levels all 1, latch A5A5, fa_out 0F0F, fb_out 3333, all enables 1, brg 0101.
    localparam vec_t VECS [6] = '{
        '{16'h0000, 16'h0000, 16'h0000, 16'hA5A5, 16'h1100, 16'h0000},
        '{16'h0000, 16'hFFFF, 16'hFFFF, 16'hA5A5, 16'h1100, 16'h0000},
        '{16'hFFFF, 16'h0000, 16'h00AA, 16'h000A, 16'hFFFF, 16'h0000},
        '{16'hFFFF, 16'hFFFF, 16'hFF52, 16'h3312, 16'h1100, 16'hFFF3},
        '{16'hFF00, 16'hF0F0, 16'hF0F0, 16'h30A5, 16'h1F00, 16'hF000},
        '{16'h8000, 16'h0000, 16'h0000, 16'h25A5, 16'h9900, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Caller sits at a falling edge; returns at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", pin_oe, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'h0, rd_v); chk("R1 assign reads 0", rd_v, 16'h0000);
        rd(4'h4, rd_v); chk("R1 direction reads 0", rd_v, 16'h0000);

        // R9 byte lanes
        wr(4'h4, 16'hFFFF, 2'b01);
        rd(4'h4, rd_v); chk("R9 low lane only", rd_v, 16'h00FF);
        wr(4'h0, 16'h1234, 2'b10);
        rd(4'h0, rd_v); chk("R9 high lane only", rd_v, 16'h1200);
        wr(4'h0, 16'h0000, 2'b11);
        wr(4'h4, 16'h0000, 2'b11);
        // R9 unused word
        wr(4'hC, 16'hFFFF, 2'b11);
        rd(4'h0, rd_v); chk("R9 unused write no alias asg", rd_v, 16'h0000);
        rd(4'h4, rd_v); chk("R9 unused write no alias dir", rd_v, 16'h0000);
        rd(4'hC, rd_v); chk("R9 unused word reads 0", rd_v, 16'h0000);

        // R3 latch loads while pins are inputs
        wr(4'h8, 16'h5A5A, 2'b11);
        chk("R3 inputs stay undriven", pin_oe, 16'h0000);
        wr(4'h4, 16'hFFFF, 2'b11);
        chk("R3 latched value driven", pin_out, 16'h5A5A);
        chk("R2 outputs enabled", pin_oe, 16'hFFFF);

        // R4 read returns synchronized pin, not latch; third-edge latency
        pin_in = 16'h1234;
        rd(4'h8, rd_v); chk("R4 first edge old level", rd_v, 16'h0000);
        rd(4'h8, rd_v); chk("R4 second edge old level", rd_v, 16'h0000);
        rd(4'h8, rd_v); chk("R4 third edge new level", rd_v, 16'h1234);

        // Vector table
        pin_in = 16'hFFFF;
        wr(4'h8, 16'hA5A5, 2'b11);
        repeat (3) @(negedge clk);
        foreach (VECS[i]) begin
            wr(4'h0, VECS[i].asg, 2'b11);
            wr(4'h4, VECS[i].dir, 2'b11);
            chk($sformatf("R2/R5/R6 oe v%0d", i), pin_oe, VECS[i].oe);
            chk($sformatf("R2/R5/R6 out v%0d", i), pin_out, VECS[i].out);
            chk($sformatf("R7 fa_in v%0d", i), fa_in, VECS[i].ain);
            chk($sformatf("R8 fb_in v%0d", i), fb_in, VECS[i].bin);
        end

        // R5 peripheral enable controls dedicated driver
        wr(4'h0, 16'hFFFF, 2'b11);
        wr(4'h4, 16'h0000, 2'b11);
        fa_oe = 16'h0000;
        #1 chk("R5 peripheral enable off", pin_oe, 16'h0000);
        fa_oe = 16'hFFFF;
        // R7 brg default follows clock change
        wr(4'h0, 16'h0000, 2'b11);
        brg_clk = 4'b1010;
        #1 chk("R7 brg defaults follow", fa_in, 16'h4400);

        // R1 reset in mid-operation
        @(negedge clk);
        wr(4'h4, 16'hFFFF, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset returns inputs", pin_oe, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule